// File: doc/BRIEF.md
# I2C Command and Receive Queue Front-End

This block sits between a host register interface and the bit-level engine of an I2C master. The host uses a single 9-bit write port to queue work. When bit 8 is set, the write is a request to read one byte from the bus. When bit 8 is clear, bits 7:0 form a byte to transmit. Both kinds of entry share one transmit command queue, in the order they were written. The engine takes entries from the head of that queue through a valid/ready handshake. It returns the bytes it reads from the bus into a receive queue, which the host drains one byte per read strobe.

Both queue levels are reported continuously and compared against host-supplied thresholds. The comparison raises a transmit-empty request, so the host knows to refill, and a receive-full request, so the host knows to drain. Single-cycle event pulses flag three cases: a host write to a full transmit queue, a host read of an empty receive queue, and an engine byte that arrives while the receive queue is full. An abort strobe from the engine empties both queues in one cycle.

Top module: `i2cq_front`

## Requirements
- R1: A write with `wr_data[8]` = 0 queues a transmit entry. At the head of the queue it appears as `cmd_read` = 0 with `cmd_byte` = `wr_data[7:0]`. Entries leave in write order, one per cycle in which `cmd_valid` and `cmd_ready` are both high.
- R2: A write with `wr_data[8]` = 1 queues a read command. It appears as `cmd_read` = 1 and uses one transmit slot, exactly like a data byte.
- R3: A `rd_en` strobe pops the oldest received byte. That byte is on `rd_data` from the next cycle and stays there until the next strobe.
- R4: `tx_level` and `rx_level` always equal the number of stored entries, from 0 to DEPTH. A push and a pop that are both accepted in the same cycle leave the level unchanged.
- R5: `tx_empty_req` is high exactly while `tx_level` <= `tx_thresh`.
- R6: `rx_full_req` is high exactly while `rx_level` > `rx_thresh`.
- R7: A host write made while the transmit queue was full at the start of the cycle is dropped, even if the engine pops in that same cycle. The queue contents are unchanged, and `tx_ovf` pulses high for one cycle on the next cycle.
- R8: A read strobe made while the receive queue is empty puts 0 on `rd_data` and pulses `rx_unf` for one cycle.
- R9: `rxb_ready` is low while the receive queue is full. An engine byte presented at that time is dropped, and `rx_ovf` pulses for one cycle.
- R10: An `abort` strobe empties both queues by the next cycle. A host write or engine byte in the same cycle is discarded and raises no overflow event.
- R11: After reset, both levels are 0, `cmd_valid` is 0, all event pulses are 0, `rd_data` is 0 and `rxb_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command/data port |
| wr_data | input | 9 | Bit 8 = read command, bits 7:0 = transmit byte |
| rd_en | input | 1 | Host read strobe, pops one received byte |
| rd_data | output | 8 | Last popped received byte |
| tx_thresh | input | LW | Transmit-empty threshold |
| rx_thresh | input | LW | Receive-full threshold |
| tx_level | output | LW | Transmit queue entry count |
| rx_level | output | LW | Receive queue entry count |
| tx_empty_req | output | 1 | Transmit level at or below threshold |
| rx_full_req | output | 1 | Receive level above threshold |
| tx_ovf | output | 1 | Write to full transmit queue (pulse) |
| rx_unf | output | 1 | Read of empty receive queue (pulse) |
| rx_ovf | output | 1 | Engine byte dropped on full receive queue (pulse) |
| abort | input | 1 | Transfer abort, flushes both queues |
| cmd_valid | output | 1 | Transmit queue head is available |
| cmd_ready | input | 1 | Engine accepts the head entry |
| cmd_read | output | 1 | Head entry is a read command |
| cmd_byte | output | 8 | Head entry data byte |
| rxb_valid | input | 1 | Engine presents a received byte |
| rxb_data | input | 8 | Received byte from the engine |
| rxb_ready | output | 1 | Receive queue can accept a byte |

## Verification
The sharpest collisions come from a host action and an engine action landing in the same cycle. One case is a host write and an engine pop on the transmit queue. Another is a host read and an engine push on the receive queue. The bench drives both sides in one cycle, first with the queue partly filled, where the level must stay the same and the order must hold, and then with the transmit queue full, where the write must still be dropped and flagged. An abort that coincides with a write and an engine byte is also provoked. The bench judges it by zero levels and the absence of any overflow pulse.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              rd;
    logic [BYTE_W-1:0] dat;
  } i2cq_cmd_t;

  localparam int unsigned CMD_W = $bits(i2cq_cmd_t);
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      if (pop_ok)  rptr_d = ptr_inc(rptr_q);
      if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  assign head  = empty ? '0 : mem[rptr_q];
  assign count = cnt_q;

  // R4: the count never exceeds the depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LW'(DEPTH));

  // R4: an accepted push and pop in one cycle keep the count
  a_r4_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/i2cq_level_cmp.sv
module i2cq_level_cmp #(
  parameter int unsigned LW    = 4,
  parameter bit          ABOVE = 1'b0
) (
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] thresh,
  output logic          req
);

  generate
    if (ABOVE) begin : g_above
      assign req = (level > thresh);
    end else begin : g_at_or_below
      assign req = (level <= thresh);
    end
  endgenerate

endmodule

// File: rtl/i2cq_front.sv
module i2cq_front
  import i2cq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [LW-1:0]     tx_thresh,
  input  logic [LW-1:0]     rx_thresh,
  output logic [LW-1:0]     tx_level,
  output logic [LW-1:0]     rx_level,
  output logic              tx_empty_req,
  output logic              rx_full_req,
  output logic              tx_ovf,
  output logic              rx_unf,
  output logic              rx_ovf,
  input  logic              abort,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_read,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rxb_valid,
  input  logic [BYTE_W-1:0] rxb_data,
  output logic              rxb_ready
);

  i2cq_cmd_t         cmd_in, cmd_head;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic              tx_ovf_d, rx_ovf_d, rx_unf_d;
  logic [BYTE_W-1:0] rd_data_d;

  assign cmd_in = wr_data;

  i2cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (abort),
    .push      (wr_en),
    .push_data (cmd_in),
    .pop       (cmd_ready),
    .head      (cmd_head),
    .count     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  i2cq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (abort),
    .push      (rxb_valid),
    .push_data (rxb_data),
    .pop       (rd_en),
    .head      (rx_head),
    .count     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  i2cq_level_cmp #(.LW(LW), .ABOVE(1'b0)) u_tx_cmp (
    .level  (tx_level),
    .thresh (tx_thresh),
    .req    (tx_empty_req)
  );

  i2cq_level_cmp #(.LW(LW), .ABOVE(1'b1)) u_rx_cmp (
    .level  (rx_level),
    .thresh (rx_thresh),
    .req    (rx_full_req)
  );

  assign cmd_valid = ~tx_empty;
  assign cmd_read  = cmd_head.rd;
  assign cmd_byte  = cmd_head.dat;
  assign rxb_ready = ~rx_full;

  always_comb begin
    tx_ovf_d  = wr_en & tx_full & ~abort;
    rx_ovf_d  = rxb_valid & rx_full & ~abort;
    rx_unf_d  = rd_en & rx_empty;
    rd_data_d = rd_en ? rx_head : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf  <= 1'b0;
      rx_ovf  <= 1'b0;
      rx_unf  <= 1'b0;
      rd_data <= '0;
    end else begin
      tx_ovf  <= tx_ovf_d;
      rx_ovf  <= rx_ovf_d;
      rx_unf  <= rx_unf_d;
      rd_data <= rd_data_d;
    end
  end

  // R10: abort leaves both queues empty with no overflow event
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (tx_level == '0 && rx_level == '0 && !tx_ovf && !rx_ovf));

  // R7: a write against a full transmit queue is flagged
  a_r7_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_level == LW'(DEPTH) && !abort) |=> tx_ovf);

  // R8: reading an empty receive queue yields zero and an event
  a_r8_rx_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_level == '0) |=> (rx_unf && rd_data == '0));

  // R9: the engine is never told there is room in a full queue
  a_r9_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_ready |-> (rx_level < LW'(DEPTH)));

  // R1: an entry is offered only while one is stored
  a_r1_valid_level: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (tx_level != '0));

  // R4: a lone accepted write raises the transmit level by one
  a_r4_tx_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !abort && tx_level < LW'(DEPTH) && !(cmd_valid && cmd_ready))
      |=> (tx_level == LW'($past(tx_level) + 1'b1)));

endmodule

// File: tb/sim_i2cq_front.sv
module sim_i2cq_front;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int LW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en, abort, cmd_ready, rxb_valid;
  logic [8:0]    wr_data;
  logic [7:0]    rd_data, cmd_byte, rxb_data;
  logic [LW-1:0] tx_thresh, rx_thresh, tx_level, rx_level;
  logic          tx_empty_req, rx_full_req, tx_ovf, rx_unf, rx_ovf;
  logic          cmd_valid, cmd_read, rxb_ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2cq_front #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tx_thresh(tx_thresh),
    .rx_thresh(rx_thresh), .tx_level(tx_level), .rx_level(rx_level),
    .tx_empty_req(tx_empty_req), .rx_full_req(rx_full_req),
    .tx_ovf(tx_ovf), .rx_unf(rx_unf), .rx_ovf(rx_ovf), .abort(abort),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_byte(cmd_byte), .rxb_valid(rxb_valid), .rxb_data(rxb_data),
    .rxb_ready(rxb_ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all helpers start and end just after a falling edge
  task automatic host_wr(input logic [8:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    rxb_data = b; rxb_valid = 1'b1;
    @(negedge clk);
    rxb_valid = 1'b0;
  endtask

  task automatic eng_pop(output logic [8:0] got);
    got = {cmd_read, cmd_byte};
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 tx_level", tx_level, 0);
    check("R11 rx_level", rx_level, 0);
    check("R11 cmd_valid", cmd_valid, 0);
    check("R11 events", {tx_ovf, rx_unf, rx_ovf}, 0);
    check("R11 rd_data", rd_data, 0);
    check("R11 rxb_ready", rxb_ready, 1);
    check("R5 reset tx_empty_req", tx_empty_req, 1);
    check("R6 reset rx_full_req", rx_full_req, 0);
  endtask

  task automatic t_cmd_queue();
    logic [8:0] g;
    host_wr(9'h0A5);
    host_wr(9'h100);
    host_wr(9'h03C);
    check("R4 tx_level after 3 writes", tx_level, 3);
    check("R2 read cmd holds a slot", cmd_valid, 1);
    eng_pop(g); check("R1 first entry data", g, 9'h0A5);
    eng_pop(g); check("R2 read command tag", g, 9'h100);
    eng_pop(g); check("R1 third entry data", g, 9'h03C);
    check("R1 queue drained", cmd_valid, 0);
  endtask

  task automatic t_thresholds();
    logic [8:0] g;
    tx_thresh = 2; rx_thresh = 0; #1;
    host_wr(9'h001);
    host_wr(9'h002);
    check("R5 level 2 at thresh 2", tx_empty_req, 1);
    host_wr(9'h003);
    check("R5 level 3 above thresh 2", tx_empty_req, 0);
    eng_pop(g);
    check("R5 back to level 2", tx_empty_req, 1);
    eng_pop(g); eng_pop(g);
    check("R6 empty rx no request", rx_full_req, 0);
    eng_push(8'h11);
    check("R6 level 1 above thresh 0", rx_full_req, 1);
    rx_thresh = 1; #1;
    check("R6 level 1 at thresh 1", rx_full_req, 0);
    eng_push(8'h22);
    check("R6 level 2 above thresh 1", rx_full_req, 1);
    host_rd(); check("R3 first rx byte", rd_data, 8'h11);
    host_rd(); check("R3 second rx byte", rd_data, 8'h22);
    rx_thresh = 0;
  endtask

  task automatic t_tx_overflow();
    logic [8:0] g;
    for (int i = 0; i < DEPTH; i++) host_wr(9'(8'h10 + i));
    check("R4 tx full level", tx_level, DEPTH);
    check("R7 no event while filling", tx_ovf, 0);
    host_wr(9'h0EE);
    check("R7 tx_ovf pulse", tx_ovf, 1);
    check("R7 level stays full", tx_level, DEPTH);
    @(negedge clk);
    check("R7 tx_ovf one cycle", tx_ovf, 0);
    // write and engine pop in the same cycle while full
    g = {cmd_read, cmd_byte};
    wr_data = 9'h0DD; wr_en = 1'b1; cmd_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cmd_ready = 1'b0;
    check("R7 popped head", g, 9'h010);
    check("R7 full write with pop dropped", tx_ovf, 1);
    check("R7 level after pop", tx_level, DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) begin
      eng_pop(g);
      check("R7 contents unchanged", g, 9'(8'h10 + i));
    end
    check("R7 drained", tx_level, 0);
  endtask

  task automatic t_rx_path();
    host_rd();
    check("R8 empty read gives 0", rd_data, 0);
    check("R8 rx_unf pulse", rx_unf, 1);
    @(negedge clk);
    check("R8 rx_unf one cycle", rx_unf, 0);
    for (int i = 0; i < DEPTH; i++) eng_push(8'(8'h80 + i));
    check("R4 rx full level", rx_level, DEPTH);
    check("R9 ready low when full", rxb_ready, 0);
    eng_push(8'hFF);
    check("R9 rx_ovf pulse", rx_ovf, 1);
    check("R9 level stays full", rx_level, DEPTH);
    @(negedge clk);
    check("R9 rx_ovf one cycle", rx_ovf, 0);
    for (int i = 0; i < DEPTH; i++) begin
      host_rd();
      check("R3 rx order", rd_data, 8'h80 + i);
    end
    @(negedge clk);
    check("R3 rd_data held", rd_data, 8'h87);
    check("R9 ready back", rxb_ready, 1);
  endtask

  task automatic t_simultaneous();
    logic [8:0] g;
    host_wr(9'h001);
    host_wr(9'h002);
    g = {cmd_read, cmd_byte};
    wr_data = 9'h103; wr_en = 1'b1; cmd_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cmd_ready = 1'b0;
    check("R4 simultaneous tx head", g, 9'h001);
    check("R4 tx level unchanged", tx_level, 2);
    eng_push(8'h44);
    rd_en = 1'b1; rxb_data = 8'h55; rxb_valid = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rxb_valid = 1'b0;
    check("R4 simultaneous rx read", rd_data, 8'h44);
    check("R4 rx level unchanged", rx_level, 1);
    host_rd(); check("R3 later rx byte", rd_data, 8'h55);
    eng_pop(g); check("R1 order kept", g, 9'h002);
    eng_pop(g); check("R2 order kept", g, 9'h103);
  endtask

  task automatic t_abort();
    logic [8:0] g;
    for (int i = 0; i < DEPTH; i++) host_wr(9'(i));
    eng_push(8'hA1);
    eng_push(8'hA2);
    wr_data = 9'h1AA; wr_en = 1'b1; rxb_data = 8'hA3; rxb_valid = 1'b1;
    abort = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rxb_valid = 1'b0; abort = 1'b0;
    check("R10 tx flushed", tx_level, 0);
    check("R10 rx flushed", rx_level, 0);
    check("R10 no tx_ovf", tx_ovf, 0);
    check("R10 no rx_ovf", rx_ovf, 0);
    check("R10 cmd_valid low", cmd_valid, 0);
    host_wr(9'h05A);
    eng_pop(g);
    check("R10 queue usable after flush", g, 9'h05A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; abort = 1'b0;
    cmd_ready = 1'b0; rxb_valid = 1'b0; wr_data = '0; rxb_data = '0;
    tx_thresh = 2; rx_thresh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_queue();
    t_thresholds();
    t_tx_overflow();
    t_rx_path();
    t_simultaneous();
    t_abort();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule